// File: doc/BRIEF.md
# Oversampled Serial Receiver with Status-Tagged Receive Queue

This block receives asynchronous serial characters of one fixed shape (one start bit, eight data bits sent least significant bit first, no parity, one stop bit) and stores each one in a 64-entry queue. The bit clock comes from an 8-bit rate divider followed by a fixed 14x oversampling counter. Every read of the queue returns the character together with tag bits for framing error and line break, plus a flag that marks a read of an empty queue. The block also keeps sticky error flags, a live fill-level trigger, an idle timeout and one interrupt line.

Software reaches the block through a small word-addressed register port. Register reads are combinational. Writes, and the pop caused by reading the data register, take effect at the clock edge. The word addresses are: 0 for the data queue (a read pops), 1 for the fill level, 2 for status (writing a 1 clears a sticky bit), 3 for control and 4 for the rate divider.

The receiver is a state machine with five states. `ST_IDLE` moves to `ST_START` when the line is seen low. `ST_START` returns to `ST_IDLE` if the line is high at the sample point (a false start) and moves on to `ST_DATA` at the end of the bit. `ST_DATA` moves to `ST_STOP` after the eighth data bit ends. At its sample point, `ST_STOP` delivers the frame and then goes to `ST_IDLE` if the stop bit is high, or to `ST_HOLD` if it is low. `ST_HOLD` returns to `ST_IDLE` once the line goes high.

Top module: `osrx_uart`

## Requirements
- R1: One bit lasts (N+1)*14 clock cycles, where N is the rate register at address 4, bits 7:0. N resets to 0xFF.
- R2: A start bit is accepted only if the line is still low at the sample point. A frame is then taken as 8 data bits, least significant first, followed by one stop bit. A shorter low pulse stores nothing.
- R3: A read of address 0 returns the oldest entry: data in bits 7:0, bit 8 clear, framing error in bit 9, break in bit 10. The read removes that entry. A read of an empty queue returns 0x100 and removes nothing.
- R4: Address 1, bits 7:0, holds the number of stored entries. The queue holds 64 entries and the level resets to 0.
- R5: A character that arrives while 64 entries are stored is discarded, and status bit 5 (overrun) latches.
- R6: A stop bit sampled low stores the character with bit 9 set and latches status bit 3.
- R7: A character of all zeros whose stop bit is low also sets bit 10 and latches status bit 4. The receiver then waits for the line to go high before it accepts another start bit, so a long low line stores exactly one entry.
- R8: Control bits 4:2 select a trigger level: 0→1, 1→4, 2→8, 3→16, 4→32, and 5 or above→48 bytes. Status bit 1 is live and reads 1 while the level is at or above the selected value.
- R9: Control bits 17:16 select the idle timeout: 0 turns it off; 1, 2 and 3 select 4, 8 and 16 character times of 140 oversample ticks each. The time is counted while the queue holds data and the receiver is idle, and restarts on any line activity or queue read. When it expires, status bit 2 sets; the bit clears when the queue empties.
- R10: Writing 1 to status bits 3, 4 or 5 clears that bit and leaves the others unchanged. If a new event arrives in the same cycle, the event wins.
- R11: irq_out is (control bit 6 AND (status bit 1 OR status bit 2)) OR (control bit 7 AND (status bit 3, 4 or 5)). Control bits 6 and 7 reset to 0.
- R12: Control bits 13:9 set the oversample tick, counted from 0 and taken from the start of each bit, at which the line is sampled. Values above 13 act as 13. The field resets to 7, so control reads 0x00000E00 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| serial_in | input | 1 | Serial receive line, idle high |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench sends a low pulse of 12 clock cycles twice: once with the sample point at tick 7 and once with it at tick 2. A design that confirms the start bit on the edge alone, or that ignores the offset field, would store a ghost character in the first case or drop the real one in the second. A held-low break must leave exactly one tagged entry; a receiver that re-arms while the line is still low would fill the queue with breaks. Sending 65 characters without reading must keep the first 64 in order and latch overrun; a design that overwrites the newest entry or wraps its count to zero would fail the drain comparison. The idle timeout is checked just before and just after the 4-character and 8-character limits, which catches a wrong character length or a counter that never restarts.

// File: rtl/osrx_pkg.sv
package osrx_pkg;

    localparam int OS_TICKS   = 14;             // oversample ticks per bit
    localparam int FRAME_BITS = 10;             // start + 8 data + stop
    localparam int CHAR_TICKS = OS_TICKS * FRAME_BITS;

    // status bit positions (software decodes these)
    localparam int SB_TRIG = 1;
    localparam int SB_TMO  = 2;
    localparam int SB_FE   = 3;
    localparam int SB_BRK  = 4;
    localparam int SB_OE   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

    typedef enum logic [2:0] {
        A_DATA   = 3'd0,
        A_LEVEL  = 3'd1,
        A_STATUS = 3'd2,
        A_CTRL   = 3'd3,
        A_RATE   = 3'd4
    } reg_addr_t;

    typedef struct packed {
        logic       brk;
        logic       fe;
        logic [7:0] data;
    } rx_word_t;

    function automatic logic [6:0] trig_bytes(input logic [2:0] sel);
        case (sel)
            3'd0:    return 7'd1;
            3'd1:    return 7'd4;
            3'd2:    return 7'd8;
            3'd3:    return 7'd16;
            3'd4:    return 7'd32;
            default: return 7'd48;
        endcase
    endfunction

endpackage

// File: rtl/osrx_baud.sv
module osrx_baud #(
    parameter int RATE_W = 8,
    parameter int OS     = osrx_pkg::OS_TICKS,
    parameter int OS_W   = $clog2(OS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic [RATE_W-1:0] rate,
    input  logic [OS_W-1:0]   samp_pt,
    output logic              samp_stb,
    output logic              bit_end
);

    logic [RATE_W-1:0] div_q;
    logic [OS_W-1:0]   os_q;
    logic              tick;

    assign tick = (div_q == rate) && !hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            os_q  <= '0;
        end else if (hold) begin
            div_q <= '0;
            os_q  <= '0;
        end else if (div_q == rate) begin
            div_q <= '0;
            os_q  <= (os_q == OS_W'(OS - 1)) ? '0 : os_q + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign samp_stb = tick && (os_q == samp_pt);
    assign bit_end  = tick && (os_q == OS_W'(OS - 1));

    p_os_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        os_q < OS_W'(OS));

    p_hold_zeroes_r1: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (os_q == '0));

endmodule

// File: rtl/osrx_deser.sv
module osrx_deser
    import osrx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     rx,
    input  logic     samp_stb,
    input  logic     bit_end,
    output logic     hold,
    output logic     busy,
    output logic     frm_valid,
    output rx_word_t frm_word
);

    rx_state_t  state, nxt;
    logic [7:0] shreg;
    logic [2:0] bit_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state and outputs
    always_comb begin
        nxt       = state;
        frm_valid = 1'b0;
        unique case (state)
            ST_IDLE:  if (!rx) nxt = ST_START;
            ST_START: begin
                if (samp_stb && rx) nxt = ST_IDLE;
                else if (bit_end)   nxt = ST_DATA;
            end
            ST_DATA:  if (bit_end && bit_idx == 3'd7) nxt = ST_STOP;
            ST_STOP:  begin
                if (samp_stb) begin
                    frm_valid = 1'b1;
                    nxt       = rx ? ST_IDLE : ST_HOLD;
                end
            end
            ST_HOLD:  if (rx) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_idx <= '0;
        end else if (state == ST_IDLE) begin
            bit_idx <= '0;
        end else if (state == ST_DATA) begin
            if (samp_stb) shreg   <= {rx, shreg[7:1]};
            if (bit_end)  bit_idx <= bit_idx + 1'b1;
        end
    end

    assign hold          = (state == ST_IDLE);
    assign busy          = (state != ST_IDLE);
    assign frm_word.data = shreg;
    assign frm_word.fe   = !rx;
    assign frm_word.brk  = !rx && (shreg == 8'h00);

    p_frame_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |=> !frm_valid);

    p_brk_is_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && frm_word.brk) |-> frm_word.fe);

    p_hold_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rx) |=> (state == ST_HOLD));

endmodule

// File: rtl/osrx_fifo.sv
module osrx_fifo #(
    parameter int DEPTH = 64,
    parameter int W     = 10,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/osrx_idle.sv
module osrx_idle #(
    parameter int RATE_W = 8,
    parameter int CHARS  = osrx_pkg::CHAR_TICKS,
    parameter int LIM_W  = $clog2(CHARS * 16 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate,
    input  logic [1:0]        sel,
    input  logic              line_busy,
    input  logic              nonempty,
    input  logic              pop,
    output logic              expired
);

    logic [RATE_W-1:0] div_q;
    logic [LIM_W-1:0]  cnt_q;
    logic [LIM_W-1:0]  limit;
    logic              tick;

    always_comb begin
        case (sel)
            2'd1:    limit = LIM_W'(CHARS * 4 - 1);
            2'd2:    limit = LIM_W'(CHARS * 8 - 1);
            default: limit = LIM_W'(CHARS * 16 - 1);
        endcase
    end

    assign tick = (div_q == rate);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= tick ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (sel == 2'd0 || !nonempty) begin
            cnt_q   <= '0;
            expired <= 1'b0;
        end else if (line_busy || pop) begin
            cnt_q   <= '0;
        end else if (tick && !expired) begin
            if (cnt_q == limit) expired <= 1'b1;
            else                cnt_q   <= cnt_q + 1'b1;
        end
    end

    p_tmo_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> !expired);

    p_tmo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'd0) |=> !expired);

endmodule

// File: rtl/osrx_uart.sv
module osrx_uart
    import osrx_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int RATE_W = 8,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        serial_in,
    output logic        irq_out
);

    localparam int OS_W = $clog2(OS_TICKS);

    // configuration and sticky status
    logic [RATE_W-1:0] rate_q;
    logic [2:0]        trig_sel;
    logic [1:0]        tmo_sel;
    logic [4:0]        samp_off;
    logic              rx_ie, err_ie;
    logic              sts_fe, sts_brk, sts_oe;

    logic              rx_meta, rx_s;
    logic              baud_hold, samp_stb, bit_end, rx_busy;
    logic              frm_valid;
    rx_word_t          frm_word;
    logic [9:0]        fifo_rd;
    logic [CW-1:0]     fifo_count;
    logic              fifo_full, fifo_empty, fifo_pop;
    logic              trig_hit, tmo_hit;
    logic [OS_W-1:0]   samp_pt;
    logic              wr_ctrl, wr_rate, wr_sts, rd_data;
    logic              fe_set, brk_set, oe_set;
    logic              unused_wbits;

    assign unused_wbits = ^{bus_wdata[31:18], bus_wdata[15:14], bus_wdata[8]};

    assign wr_ctrl  = bus_sel && bus_wr && (bus_addr == A_CTRL);
    assign wr_rate  = bus_sel && bus_wr && (bus_addr == A_RATE);
    assign wr_sts   = bus_sel && bus_wr && (bus_addr == A_STATUS);
    assign rd_data  = bus_sel && !bus_wr && (bus_addr == A_DATA);
    assign fifo_pop = rd_data && !fifo_empty;

    assign samp_pt  = (samp_off > 5'd13) ? OS_W'(13) : OS_W'(samp_off);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_s    <= 1'b1;
        end else begin
            rx_meta <= serial_in;
            rx_s    <= rx_meta;
        end
    end

    osrx_baud #(.RATE_W(RATE_W), .OS(OS_TICKS)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (baud_hold),
        .rate     (rate_q),
        .samp_pt  (samp_pt),
        .samp_stb (samp_stb),
        .bit_end  (bit_end)
    );

    osrx_deser u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx        (rx_s),
        .samp_stb  (samp_stb),
        .bit_end   (bit_end),
        .hold      (baud_hold),
        .busy      (rx_busy),
        .frm_valid (frm_valid),
        .frm_word  (frm_word)
    );

    osrx_fifo #(.DEPTH(DEPTH), .W(10)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (frm_valid),
        .wdata (frm_word),
        .pop   (fifo_pop),
        .rdata (fifo_rd),
        .count (fifo_count),
        .full  (fifo_full),
        .empty (fifo_empty)
    );

    osrx_idle #(.RATE_W(RATE_W), .CHARS(CHAR_TICKS)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .rate      (rate_q),
        .sel       (tmo_sel),
        .line_busy (rx_busy),
        .nonempty  (!fifo_empty),
        .pop       (fifo_pop),
        .expired   (tmo_hit)
    );

    assign trig_hit = (fifo_count >= CW'(trig_bytes(trig_sel)));
    assign fe_set   = frm_valid && frm_word.fe;
    assign brk_set  = frm_valid && frm_word.brk;
    assign oe_set   = frm_valid && fifo_full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rate_q   <= '1;
            trig_sel <= '0;
            tmo_sel  <= '0;
            samp_off <= 5'd7;
            rx_ie    <= 1'b0;
            err_ie   <= 1'b0;
            sts_fe   <= 1'b0;
            sts_brk  <= 1'b0;
            sts_oe   <= 1'b0;
        end else begin
            if (wr_rate) rate_q <= bus_wdata[RATE_W-1:0];
            if (wr_ctrl) begin
                trig_sel <= bus_wdata[4:2];
                rx_ie    <= bus_wdata[6];
                err_ie   <= bus_wdata[7];
                samp_off <= bus_wdata[13:9];
                tmo_sel  <= bus_wdata[17:16];
            end
            sts_fe  <= fe_set  || (sts_fe  && !(wr_sts && bus_wdata[SB_FE]));
            sts_brk <= brk_set || (sts_brk && !(wr_sts && bus_wdata[SB_BRK]));
            sts_oe  <= oe_set  || (sts_oe  && !(wr_sts && bus_wdata[SB_OE]));
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_DATA: begin
                if (fifo_empty) bus_rdata[8] = 1'b1;
                else            bus_rdata = {21'b0, fifo_rd[9], fifo_rd[8], 1'b0, fifo_rd[7:0]};
            end
            A_LEVEL:  bus_rdata = 32'(fifo_count);
            A_STATUS: begin
                bus_rdata[SB_TRIG] = trig_hit;
                bus_rdata[SB_TMO]  = tmo_hit;
                bus_rdata[SB_FE]   = sts_fe;
                bus_rdata[SB_BRK]  = sts_brk;
                bus_rdata[SB_OE]   = sts_oe;
            end
            A_CTRL: begin
                bus_rdata[4:2]   = trig_sel;
                bus_rdata[6]     = rx_ie;
                bus_rdata[7]     = err_ie;
                bus_rdata[13:9]  = samp_off;
                bus_rdata[17:16] = tmo_sel;
            end
            A_RATE:   bus_rdata = 32'(rate_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign irq_out = (rx_ie && (trig_hit || tmo_hit)) ||
                     (err_ie && (sts_fe || sts_brk || sts_oe));

    p_empty_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && fifo_empty) |-> (bus_rdata[8] && bus_rdata[7:0] == 8'h00));

    p_oe_on_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && fifo_full) |=> sts_oe);

    p_oe_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && bus_wdata[SB_OE] && !oe_set) |=> !sts_oe);

    p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ie && !err_ie) |-> !irq_out);

endmodule

// File: tb/osrx_uart_test.sv
module osrx_uart_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        serial_in = 1'b1;
    logic        irq_out;

    int          n_chk = 0;
    int          n_bad = 0;
    int          bp = 28;
    bit          done = 1'b0;
    logic [31:0] exp_q[$];
    logic [31:0] rd;

    always #4 clk = ~clk;   // 125 MHz

    osrx_uart uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .serial_in (serial_in),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    function automatic logic [31:0] cw(input int trig, input int tmo, input int off,
                                       input int rxie, input int errie);
        return 32'((tmo << 16) | (off << 9) | (errie << 7) | (rxie << 6) | (trig << 2));
    endfunction

    task automatic line_for(input logic v, input int nbits);
        serial_in = v;
        repeat (nbits * bp) @(negedge clk);
    endtask

    // driver: sends one frame and records what the receiver must store
    task automatic send_frame(input logic [7:0] d, input logic stop, input bit keep,
                              input int extra_low);
        logic fe, brk;
        fe  = !stop;
        brk = !stop && (d == 8'h00);
        if (keep) exp_q.push_back({21'b0, brk, fe, 1'b0, d});
        @(negedge clk);
        line_for(1'b0, 1);
        for (int i = 0; i < 8; i++) line_for(d[i], 1);
        line_for(stop, 1);
        if (extra_low > 0) line_for(1'b0, extra_low);
        line_for(1'b1, 1);
    endtask

    task automatic pulse_low(input int clocks);
        @(negedge clk);
        serial_in = 1'b0;
        repeat (clocks) @(negedge clk);
        serial_in = 1'b1;
    endtask

    // monitor: pops each stored word and compares it against the scoreboard
    task automatic drain(input string req);
        logic [31:0] d;
        while (exp_q.size() > 0) begin
            bus_read(3'd0, d);
            chk(req, d, exp_q.pop_front());
        end
        bus_read(3'd0, d);
        chk("R3 empty read", d, 32'h0000_0100);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        bus_read(3'd2, rd); chk("R10 status after reset", rd, 32'h0);
        bus_read(3'd1, rd); chk("R4 level after reset", rd, 32'h0);
        bus_read(3'd4, rd); chk("R1 rate after reset", rd, 32'hFF);
        bus_read(3'd3, rd); chk("R12 control after reset", rd, 32'h0000_0E00);
        bus_read(3'd0, rd); chk("R3 empty after reset", rd, 32'h100);
        #1 chk("R11 irq after reset", 32'(irq_out), 32'h0);

        // R1: a slower divider value
        bus_write(3'd4, 32'd3); bp = 56;
        send_frame(8'hC6, 1'b1, 1'b1, 0);
        drain("R1 byte at rate 3");
        bus_write(3'd4, 32'd1); bp = 28;

        // R2: several patterns
        send_frame(8'h55, 1'b1, 1'b1, 0);
        send_frame(8'hA3, 1'b1, 1'b1, 0);
        send_frame(8'h00, 1'b1, 1'b1, 0);
        send_frame(8'hFF, 1'b1, 1'b1, 0);
        bus_read(3'd1, rd); chk("R4 level after four", rd, 32'd4);
        drain("R2 data pattern");

        // R2: short low pulse rejected at mid-bit sample
        pulse_low(12);
        repeat (20 * bp) @(negedge clk);
        bus_read(3'd1, rd); chk("R2 glitch rejected", rd, 32'd0);

        // R12: an early sample point accepts the same pulse
        bus_write(3'd3, cw(0, 0, 2, 0, 0));
        pulse_low(12);
        exp_q.push_back(32'h0000_00FF);
        repeat (12 * bp) @(negedge clk);
        bus_read(3'd1, rd); chk("R12 early sample accepts", rd, 32'd1);
        drain("R12 early sample data");
        bus_write(3'd3, cw(0, 0, 7, 0, 0));

        // R6: framing error
        send_frame(8'h5A, 1'b0, 1'b1, 0);
        drain("R6 framing tag");
        bus_read(3'd2, rd); chk("R6 status fe", rd, 32'h08);
        bus_write(3'd3, cw(0, 0, 7, 0, 1));
        #1 chk("R11 irq error enabled", 32'(irq_out), 32'h1);
        bus_write(3'd3, cw(0, 0, 7, 0, 0));
        #1 chk("R11 irq error masked", 32'(irq_out), 32'h0);
        bus_write(3'd2, 32'h08);
        bus_read(3'd2, rd); chk("R10 fe cleared", rd, 32'h0);

        // R7: break held low for extra bit times
        send_frame(8'h00, 1'b0, 1'b1, 3);
        bus_read(3'd1, rd); chk("R7 one entry for break", rd, 32'd1);
        drain("R7 break tag");
        bus_read(3'd2, rd); chk("R7 status brk and fe", rd, 32'h18);
        bus_write(3'd2, 32'h10);
        bus_read(3'd2, rd); chk("R10 partial clear", rd, 32'h08);
        bus_write(3'd2, 32'h08);
        bus_read(3'd2, rd); chk("R10 all clear", rd, 32'h0);

        // R5: overrun
        for (int i = 0; i < 65; i++) send_frame(8'(i * 7 + 3), 1'b1, (i < 64), 0);
        bus_read(3'd1, rd); chk("R5 level saturates", rd, 32'd64);
        drain("R5 first 64 kept");
        bus_read(3'd2, rd); chk("R5 overrun latched", rd, 32'h20);
        bus_write(3'd2, 32'h20);
        bus_read(3'd2, rd); chk("R10 oe cleared", rd, 32'h0);

        // R8: trigger level 4
        bus_write(3'd3, cw(1, 0, 7, 1, 0));
        send_frame(8'h11, 1'b1, 1'b1, 0);
        send_frame(8'h22, 1'b1, 1'b1, 0);
        send_frame(8'h33, 1'b1, 1'b1, 0);
        bus_read(3'd2, rd); chk("R8 below trigger", rd, 32'h0);
        #1 chk("R11 irq below trigger", 32'(irq_out), 32'h0);
        send_frame(8'h44, 1'b1, 1'b1, 0);
        bus_read(3'd2, rd); chk("R8 at trigger", rd, 32'h02);
        #1 chk("R11 irq at trigger", 32'(irq_out), 32'h1);
        drain("R8 data");
        bus_read(3'd2, rd); chk("R8 trigger drops", rd, 32'h0);

        // R9: 4 character timeout (560 ticks = 1120 clocks)
        bus_write(3'd3, cw(5, 1, 7, 1, 0));
        send_frame(8'h9C, 1'b1, 1'b1, 0);
        bus_read(3'd2, rd); chk("R9 no early timeout", rd, 32'h0);
        repeat (1300) @(negedge clk);
        bus_read(3'd2, rd); chk("R9 timeout after 4 chars", rd, 32'h04);
        #1 chk("R11 irq on timeout", 32'(irq_out), 32'h1);
        drain("R9 data");
        bus_read(3'd2, rd); chk("R9 timeout clears", rd, 32'h0);

        // R9: 8 character timeout (2240 clocks)
        bus_write(3'd3, cw(5, 2, 7, 0, 0));
        send_frame(8'h3E, 1'b1, 1'b1, 0);
        repeat (1300) @(negedge clk);
        bus_read(3'd2, rd); chk("R9 8-char not yet", rd, 32'h0);
        repeat (1100) @(negedge clk);
        bus_read(3'd2, rd); chk("R9 8-char expired", rd, 32'h04);
        drain("R9 8-char data");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule